// File: doc/BRIEF.md
# Run-Time Configurable Maximal-Length Sequence Generator

This block produces a serial pseudo-random bit stream of maximal length. The length of the shift register, called the order N, is picked at run time from 2 to 15. For the chosen order, a polarity input selects a fixed primitive polynomial or its mirror image. Both choices give a sequence that repeats every 2^N − 1 bits and never enters the all-zero state.

The storage is one chain of fifteen identical shift cells, and each cell has a tap-enable bit. A running feedback value passes from the top cell down to the bottom cell. Each cell whose tap bit is set XORs its own value into that running value. For order N only the upper N cells are live, and the serial output is taken from the lowest live cell.

A small front end registers an external start level into an enable. It also turns the first cycle of that enable into a one-cycle seed pulse. While the enable is low the chain is held clear. The seed pulse forces a one into the top cell and at the same time captures the order and polarity inputs for the run that follows.

Top module: `mseq_gen`

## Requirements
- R1: `start_i` is registered once on `clk` to form the internal enable. While `start_i` stays low, `bit_o` stays 0.
- R2: The seed pulse is high only in the first cycle that the enable is high. In that cycle the top cell loads 1 and the other cells load 0. The bit stream a0, a1, … then appears on `bit_o` one bit per cycle, starting with a0 after the second rising edge that samples `start_i` high. Bits a0 … a(N−2) are 0 and bit a(N−1) is 1.
- R3: At the first edge that samples the enable low, all cells clear to 0, and `bit_o` is 0 from that edge until the next seed.
- R4: With `recip_i` = 0, the stream obeys a(t+N) = XOR of a(t+k) for every term x^k (k < N) of the polynomial for order N, so the period is 2^N − 1. The polynomials are:
  - N=2, 3, 4, 6, 7 and 15: x^N+x+1
  - N=5: x^5+x^2+1
  - N=8: x^8+x^4+x^3+x^2+1
  - N=9: x^9+x^4+1
  - N=10: x^10+x^3+1
  - N=11: x^11+x^2+1
  - N=12: x^12+x^6+x^4+x+1
  - N=13: x^13+x^4+x^3+x+1
  - N=14: x^14+x^10+x^6+x+1
- R5: With `recip_i` = 1, the same recurrence uses the mirror polynomial, in which each term x^k with 1 ≤ k < N becomes x^(N−k) and the constant term stays.
- R6: Once seeded, the live cells never hold all zeros. Each period of 2^N − 1 output bits contains exactly 2^(N−1) ones.
- R7: `order_i` and `recip_i` are captured only in the seed cycle. Changing them while the enable stays high does not alter the running stream.
- R8: An `order_i` value of 0 or 1 is treated as order 2.
- R9: While `rst_n` is low, all cells and the enable are 0 and `bit_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Generator clock; one output bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Active-high run level; a low level clears the generator |
| order_i | input | 4 | Register order N (2 to 15), captured at seed |
| recip_i | input | 1 | 0 selects the forward polynomial, 1 selects the mirror polynomial |
| bit_o | output | 1 | Serial sequence output |

## Verification
Two things fall in the same cycle: the seed pulse and the capture of the configuration. In the seed cycle the top cell takes the feedback value ORed with the seed pulse, and the new order and tap set are latched at that same edge. The bench provokes this by dropping `start_i`, changing order and polarity while the chain is clear, and raising `start_i` again. It then judges the first bits, and at least one full period, against a recurrence model for each of the 28 configurations. A second case changes `order_i` and `recip_i` in the middle of a run and checks that the stream still follows the configuration captured at the seed.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int unsigned MAX_ORDER = 15;
    localparam int unsigned MIN_ORDER = 2;
    localparam int unsigned ORD_W     = $clog2(MAX_ORDER + 1);

    typedef logic [MAX_ORDER-1:0] tapvec_t;

    // Coefficients of x^k for k < N of a primitive polynomial of degree N.
    function automatic tapvec_t fwd_poly(input int unsigned n);
        tapvec_t m;
        case (n)
            5:       m = tapvec_t'(16'h0005);
            8:       m = tapvec_t'(16'h001D);
            9:       m = tapvec_t'(16'h0011);
            10:      m = tapvec_t'(16'h0009);
            11:      m = tapvec_t'(16'h0005);
            12:      m = tapvec_t'(16'h0053);
            13:      m = tapvec_t'(16'h001B);
            14:      m = tapvec_t'(16'h0443);
            default: m = tapvec_t'(16'h0003);
        endcase
        return m;
    endfunction

    // Mirror polynomial: x^k -> x^(N-k), constant term kept.
    function automatic tapvec_t rev_poly(input int unsigned n);
        tapvec_t f;
        tapvec_t r;
        f    = fwd_poly(n);
        r    = '0;
        r[0] = 1'b1;
        for (int k = 1; k < int'(MAX_ORDER); k++) begin
            if (k < int'(n) && f[k]) r[int'(n) - k] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/mseq_start_sync.sv
module mseq_start_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic en_o,
    output logic seed_o
);
    typedef struct packed {
        logic en;
        logic en_dly;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.en     = start_i;
        s_d.en_dly = s_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o   = s_q.en;
    assign seed_o = s_q.en & ~s_q.en_dly;
endmodule

// File: rtl/mseq_cfg.sv
module mseq_cfg #(
    parameter int unsigned CELLS = mseq_pkg::MAX_ORDER,
    parameter int unsigned OW    = $clog2(CELLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_i,
    input  logic [OW-1:0]    order_i,
    input  logic             recip_i,
    output logic [CELLS-1:0] taps_o,
    output logic [CELLS-1:0] active_o,
    output logic [OW-1:0]    lo_o
);
    import mseq_pkg::*;

    typedef struct packed {
        logic [OW-1:0] order;
        logic          recip;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [OW-1:0]    ord_c;
    logic [CELLS-1:0] mask_c;

    always_comb begin
        ord_c = order_i;
        if (int'(ord_c) < int'(MIN_ORDER)) ord_c = OW'(MIN_ORDER);
        if (int'(ord_c) > int'(CELLS))     ord_c = OW'(CELLS);
        cfg_d = cfg_q;
        if (seed_i) begin
            cfg_d.order = ord_c;
            cfg_d.recip = recip_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.order <= OW'(MIN_ORDER);
            cfg_q.recip <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        mask_c   = cfg_q.recip ? CELLS'(rev_poly(int'(cfg_q.order)))
                               : CELLS'(fwd_poly(int'(cfg_q.order)));
        lo_o     = OW'(int'(CELLS) - int'(cfg_q.order));
        taps_o   = mask_c << lo_o;
        active_o = {CELLS{1'b1}} << lo_o;
    end
endmodule

// File: rtl/mseq_cell.sv
module mseq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic d_i,
    input  logic fb_i,
    input  logic tap_i,
    output logic q_o,
    output logic fb_o
);
    typedef struct packed {
        logic q;
    } cell_t;

    cell_t c_d, c_q;

    always_comb begin
        c_d.q = clr_i ? 1'b0 : d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign q_o  = c_q.q;
    assign fb_o = fb_i ^ (c_q.q & tap_i);
endmodule

// File: rtl/mseq_gen.sv
module mseq_gen #(
    parameter int unsigned CELLS = mseq_pkg::MAX_ORDER,
    localparam int unsigned OW   = $clog2(CELLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [OW-1:0] order_i,
    input  logic          recip_i,
    output logic          bit_o
);
    logic             en_w;
    logic             seed_w;
    logic [CELLS-1:0] taps_w;
    logic [CELLS-1:0] act_w;
    logic [OW-1:0]    lo_w;
    logic [CELLS-1:0] q_w;
    logic [CELLS-1:0] d_w;
    logic [CELLS-1:0] fbin_w;
    logic [CELLS-1:0] fbout_w;

    mseq_start_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .en_o    (en_w),
        .seed_o  (seed_w)
    );

    mseq_cfg #(.CELLS(CELLS), .OW(OW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed_i   (seed_w),
        .order_i  (order_i),
        .recip_i  (recip_i),
        .taps_o   (taps_w),
        .active_o (act_w),
        .lo_o     (lo_w)
    );

    for (genvar i = 0; i < int'(CELLS); i++) begin : g_cell
        if (i == int'(CELLS) - 1) begin : g_head
            assign d_w[i]    = fbout_w[0] | seed_w;
            assign fbin_w[i] = 1'b0;
        end else begin : g_body
            assign d_w[i]    = q_w[i+1];
            assign fbin_w[i] = fbout_w[i+1];
        end

        mseq_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (~en_w),
            .d_i   (d_w[i]),
            .fb_i  (fbin_w[i]),
            .tap_i (taps_w[i]),
            .q_o   (q_w[i]),
            .fb_o  (fbout_w[i])
        );
    end

    always_comb begin
        bit_o = q_w[lo_w];
    end
endmodule

// File: rtl/mseq_gen_chk.sv
module mseq_gen_chk #(
    parameter int unsigned CELLS = mseq_pkg::MAX_ORDER
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             seed,
    input logic [CELLS-1:0] chain,
    input logic [CELLS-1:0] active,
    input logic             bit_o
);
    // R2
    seed_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed |-> (en && !$past(en)));

    // R2
    seed_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> !seed);

    // R3
    clear_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (chain == '0));

    // R3
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !bit_o);

    // R6
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !seed && $past(en)) |-> ((chain & active) != '0));
endmodule

bind mseq_gen mseq_gen_chk #(.CELLS(CELLS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en_w),
    .seed   (seed_w),
    .chain  (q_w),
    .active (act_w),
    .bit_o  (bit_o)
);

// File: tb/mseq_gen_tb.sv
module mseq_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] order_i = 4'd2;
    logic       recip_i = 1'b0;
    logic       bit_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    mseq_gen u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .order_i (order_i),
        .recip_i (recip_i),
        .bit_o   (bit_o)
    );

    // {order, forward coefficient mask (bit k = coefficient of x^k, k < N)}
    localparam logic [19:0] POLY_TAB [14] = '{
        {4'd2,  16'h0003}, {4'd3,  16'h0003}, {4'd4,  16'h0003},
        {4'd5,  16'h0005}, {4'd6,  16'h0003}, {4'd7,  16'h0003},
        {4'd8,  16'h001D}, {4'd9,  16'h0011}, {4'd10, 16'h0009},
        {4'd11, 16'h0005}, {4'd12, 16'h0053}, {4'd13, 16'h001B},
        {4'd14, 16'h0443}, {4'd15, 16'h0003}
    };

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] mirror(input int n, input logic [15:0] f);
        logic [15:0] r = 16'h0001;
        for (int k = 1; k < n; k++) if (f[k]) r[n-k] = 1'b1;
        return r;
    endfunction

    // Restart with a configuration, then compare nbits outputs to the recurrence.
    task automatic run_cfg(input int ord_in, input int n, input logic pol,
                           input logic [15:0] fmask, input int nbits,
                           input int chg_at, input string rq);
        logic [15:0] m;
        logic [15:0] win;
        logic        nb;
        int          errs;
        int          ones;
        int          first_t;
        int          per;
        m       = pol ? mirror(n, fmask) : fmask;
        per     = (1 << n) - 1;
        errs    = 0;
        ones    = 0;
        first_t = -1;
        @(negedge clk) start_i = 1'b0;
        repeat (2) @(negedge clk);
        order_i = 4'(ord_in);
        recip_i = pol;
        start_i = 1'b1;
        @(posedge clk); #1;
        // R2: seed cycle still shows a cleared chain
        check(bit_o === 1'b0, "R2 seed-cycle output", int'(bit_o), 0);
        win = 16'h0001 << (n - 1);
        for (int t = 0; t < nbits; t++) begin
            @(posedge clk); #1;
            if (bit_o !== win[0]) begin
                errs++;
                if (first_t < 0) first_t = t;
            end
            if (t < per && bit_o === 1'b1) ones++;
            nb  = ^(win & m);
            win = (win >> 1) | (16'(nb) << (n - 1));
            if (t == chg_at) begin
                order_i = 4'd9;
                recip_i = ~pol;
            end
        end
        check(errs == 0, $sformatf("%s sequence N=%0d pol=%0d first bad bit %0d",
              rq, n, pol, first_t), errs, 0);
        if (nbits >= per)
            check(ones == (1 << (n - 1)),
                  $sformatf("R6 ones per period N=%0d pol=%0d", n, pol), ones, 1 << (n - 1));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int zeros;
        // R9: reset state
        repeat (3) @(negedge clk);
        #1 check(bit_o === 1'b0, "R9 output in reset", int'(bit_o), 0);
        start_i = 1'b1;
        @(negedge clk);
        check(bit_o === 1'b0, "R9 start ignored in reset", int'(bit_o), 0);
        start_i = 1'b0;
        rst_n   = 1'b1;
        // R1: start low keeps output idle
        zeros = 0;
        repeat (10) begin
            @(posedge clk); #1;
            if (bit_o === 1'b0) zeros++;
        end
        check(zeros == 10, "R1 idle while start low", zeros, 10);

        // Table walk: all 28 configurations, full period plus N bits (R4, R5, R6)
        for (int i = 0; i < 14; i++) begin
            for (int p = 0; p < 2; p++) begin
                int n;
                n = int'(POLY_TAB[i][19:16]);
                run_cfg(n, n, p[0], POLY_TAB[i][15:0], (1 << n) - 1 + n, -1,
                        p == 0 ? "R4" : "R5");
            end
        end

        // R3: drop start mid-run, chain clears and stays clear
        run_cfg(5, 5, 1'b0, 16'h0005, 12, -1, "R4");
        @(negedge clk) start_i = 1'b0;
        @(posedge clk);
        @(posedge clk); #1;
        check(bit_o === 1'b0, "R3 cleared after enable falls", int'(bit_o), 0);
        zeros = 0;
        repeat (8) begin
            @(posedge clk); #1;
            if (bit_o === 1'b0) zeros++;
        end
        check(zeros == 8, "R3 stays clear", zeros, 8);

        // R7: config change while enabled is ignored
        run_cfg(4, 4, 1'b0, 16'h0003, 40, 3, "R7");
        run_cfg(7, 7, 1'b1, 16'h0003, 60, 0, "R7");

        // R8: order 0 and 1 behave as order 2
        run_cfg(0, 2, 1'b0, 16'h0003, 9, -1, "R8");
        run_cfg(1, 2, 1'b1, 16'h0003, 9, -1, "R8");

        // R2: restart after a run reseeds from the same start state
        run_cfg(3, 3, 1'b0, 16'h0003, 10, -1, "R2");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule